// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block sits in a host bridge and routes every processor memory access that lands in the legacy hole below one megabyte. For each access it decides whether system DRAM serves the access, or whether the access is passed out to the expansion bus. Addresses from 0xC0000 to 0xFFFFF are governed by 2-bit attribute fields packed two per byte in a small register bank. The 0xA0000 to 0xBFFFF video window is governed by a separate SMRAM control byte together with an input that says the processor is in system management mode.

Software programs the bank through a byte-wide configuration write port addressed by configuration offset. An access is presented as an address, a write flag and a valid strobe. One clock later exactly one of three outputs (DRAM read enable, DRAM write enable, forward to bus) is raised, or none when the access is a write into read-only DRAM. Addresses outside the legacy hole always go to DRAM.

Top module: `legacy_mem_decoder`

## Requirements
- R1: After reset every attribute byte is 0x00 and the SMRAM control byte is 0x02, so every access from 0xA0000 to 0xFFFFF is forwarded to the bus, with the SMM input high or low.
- R2: The 64 KB range 0xF0000 to 0xFFFFF takes its attribute from bits [5:4] of configuration offset 0x59.
- R3: The range 0xC0000 to 0xEFFFF is twelve 16 KB segments. Segment i (i = address minus 0xC0000, divided by 0x4000) takes its attribute from offset 0x5A + (i>>1), bits [4*(i&1)+1 : 4*(i&1)]. The other bits of each byte have no effect on routing.
- R4: Attribute 3 gives read/write DRAM. A read raises only the DRAM read enable, and a write raises only the DRAM write enable.
- R5: Attribute 1 gives read-only DRAM. A read raises only the DRAM read enable. A write raises none of the three outputs.
- R6: Attributes 0 and 2 forward reads and writes to the bus: only the forward output is raised.
- R7: The 0xA0000 to 0xBFFFF window is read/write DRAM when (SMM input high AND bit 3 of offset 0x72) OR bit 6 of offset 0x72 is set. Otherwise it is forwarded to the bus.
- R8: Any address below 0xA0000 or at or above 0x100000 is read/write DRAM, whatever the register contents.
- R9: Configuration writes to offsets other than 0x59 to 0x5F and 0x72 change no routing decision.
- R10: The outputs are registered. They reflect the access presented at the previous rising edge, are all low in the cycle after a cycle with no valid access, and at most one of them is high at a time. A configuration write is seen by an access presented on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_wr_addr | input | 8 | Configuration offset |
| cfg_wr_data | input | 8 | Configuration byte value |
| smm_active | input | 1 | Processor is in system management mode |
| acc_valid | input | 1 | Memory access present |
| acc_is_write | input | 1 | Access is a write (1) or read (0) |
| acc_addr | input | ADDR_W | Access byte address |
| dram_rd_en | output | 1 | DRAM serves this read |
| dram_wr_en | output | 1 | DRAM accepts this write |
| fwd_to_bus | output | 1 | Access is passed to the expansion bus |

## Verification
The checker assumes that reset is held for at least one edge and that `acc_is_write` and `acc_addr` carry known values whenever `acc_valid` is high. It also assumes that configuration writes and accesses may share a cycle without an ordering hazard, because a write lands at the edge and the access sees the old value. The bench drives every input on the falling edge and samples on the next falling edge. Each access therefore meets exactly one rising edge, and no access is issued in the same cycle as a configuration write that targets its own region.

// File: rtl/legacy_mem_pkg.sv
package legacy_mem_pkg;

    typedef enum logic [1:0] {
        RT_DRAM_RW = 2'd0,
        RT_DRAM_RO = 2'd1,
        RT_BUS     = 2'd2
    } route_t;

    localparam logic [1:0] ATTR_CODE_RW = 2'd3;
    localparam logic [1:0] ATTR_CODE_RO = 2'd1;

    localparam logic [19:0] VIDEO_BASE = 20'hA0000;
    localparam logic [19:0] SEG_BASE   = 20'hC0000;
    localparam int          SEG_SHIFT  = 14;

    function automatic route_t attr_to_route(input logic [1:0] code);
        route_t r;
        unique case (code)
            ATTR_CODE_RW: r = RT_DRAM_RW;
            ATTR_CODE_RO: r = RT_DRAM_RO;
            default:      r = RT_BUS;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/legacy_attr_regs.sv
module legacy_attr_regs #(
    parameter logic [7:0] ATTR_BASE  = 8'h59,
    parameter int         ATTR_BYTES = 7,
    parameter logic [7:0] SMRAM_OFF  = 8'h72,
    parameter logic [7:0] SMRAM_RST  = 8'h02
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] attr_q [ATTR_BYTES],
    output logic [7:0] smram_q
);

    for (genvar b = 0; b < ATTR_BYTES; b++) begin : g_attr
        localparam logic [7:0] OFF = ATTR_BASE + 8'(b);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                attr_q[b] <= 8'h00;
            end else if (wr_en && wr_addr == OFF) begin
                attr_q[b] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smram_q <= SMRAM_RST;
        end else if (wr_en && wr_addr == SMRAM_OFF) begin
            smram_q <= wr_data;
        end
    end

endmodule

// File: rtl/legacy_region_lookup.sv
module legacy_region_lookup
    import legacy_mem_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ATTR_BYTES = 7
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        attr_q [ATTR_BYTES],
    input  logic [7:0]        smram_q,
    input  logic              smm_active,
    output route_t            route
);

    localparam int SEG_CNT = 2 * (ATTR_BYTES - 1);
    localparam int SEG_W   = (SEG_CNT > 1) ? $clog2(SEG_CNT) : 1;

    logic [1:0]  seg_attr [SEG_CNT];
    logic [19:0] low_addr;
    logic [19:0] seg_off;
    logic [SEG_W-1:0] seg_idx;
    logic        above_1m;
    logic        video_open;

    for (genvar s = 0; s < SEG_CNT; s++) begin : g_seg
        assign seg_attr[s] = attr_q[1 + s/2][4*(s%2) +: 2];
    end

    assign low_addr   = addr[19:0];
    assign above_1m   = |(addr >> 20);
    assign seg_off    = low_addr - SEG_BASE;
    assign seg_idx    = seg_off[SEG_SHIFT +: SEG_W];
    assign video_open = (smm_active && smram_q[3]) || smram_q[6];

    always_comb begin
        if (above_1m || low_addr < VIDEO_BASE) begin
            route = RT_DRAM_RW;
        end else if (low_addr < SEG_BASE) begin
            route = video_open ? RT_DRAM_RW : RT_BUS;
        end else if (low_addr[19:16] == 4'hF) begin
            route = attr_to_route(attr_q[0][5:4]);
        end else if (32'(seg_idx) < SEG_CNT) begin
            route = attr_to_route(seg_attr[seg_idx]);
        end else begin
            route = RT_BUS;
        end
    end

endmodule

// File: rtl/legacy_mem_decoder.sv
module legacy_mem_decoder
    import legacy_mem_pkg::*;
#(
    parameter int         ADDR_W     = 32,
    parameter logic [7:0] ATTR_BASE  = 8'h59,
    parameter int         ATTR_BYTES = 7,
    parameter logic [7:0] SMRAM_OFF  = 8'h72,
    parameter logic [7:0] SMRAM_RST  = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [7:0]        cfg_wr_addr,
    input  logic [7:0]        cfg_wr_data,
    input  logic              smm_active,
    input  logic              acc_valid,
    input  logic              acc_is_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              dram_rd_en,
    output logic              dram_wr_en,
    output logic              fwd_to_bus
);

    logic [7:0] attr_q [ATTR_BYTES];
    logic [7:0] smram_q;
    route_t     route;
    logic       rd_d, wr_d, fwd_d;

    legacy_attr_regs #(
        .ATTR_BASE (ATTR_BASE),
        .ATTR_BYTES(ATTR_BYTES),
        .SMRAM_OFF (SMRAM_OFF),
        .SMRAM_RST (SMRAM_RST)
    ) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr_en),
        .wr_addr(cfg_wr_addr),
        .wr_data(cfg_wr_data),
        .attr_q (attr_q),
        .smram_q(smram_q)
    );

    legacy_region_lookup #(
        .ADDR_W    (ADDR_W),
        .ATTR_BYTES(ATTR_BYTES)
    ) i_lookup (
        .addr      (acc_addr),
        .attr_q    (attr_q),
        .smram_q   (smram_q),
        .smm_active(smm_active),
        .route     (route)
    );

    always_comb begin
        rd_d  = 1'b0;
        wr_d  = 1'b0;
        fwd_d = 1'b0;
        if (acc_valid) begin
            unique case (route)
                RT_DRAM_RW: begin
                    rd_d = !acc_is_write;
                    wr_d = acc_is_write;
                end
                RT_DRAM_RO: begin
                    rd_d = !acc_is_write;
                end
                default: begin
                    fwd_d = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dram_rd_en <= 1'b0;
            dram_wr_en <= 1'b0;
            fwd_to_bus <= 1'b0;
        end else begin
            dram_rd_en <= rd_d;
            dram_wr_en <= wr_d;
            fwd_to_bus <= fwd_d;
        end
    end

endmodule

// File: rtl/legacy_mem_decoder_chk.sv
module legacy_mem_decoder_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_is_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              dram_rd_en,
    input logic              dram_wr_en,
    input logic              fwd_to_bus
);

    logic outside;
    assign outside = (|(acc_addr >> 20)) || (acc_addr[19:0] < 20'hA0000);

    // R10: never more than one output raised
    a_r10_one_output: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dram_rd_en, dram_wr_en, fwd_to_bus}));

    // R10: quiet after a cycle without an access
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !(dram_rd_en || dram_wr_en || fwd_to_bus));

    // R8: outside the hole a read goes to DRAM
    a_r8_outside_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_is_write && outside) |=> dram_rd_en);

    // R8: outside the hole a write goes to DRAM
    a_r8_outside_write: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_is_write && outside) |=> dram_wr_en);

    // R4: a read never raises the write enable
    a_r4_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_is_write) |=> !dram_wr_en);

    // R5: a write never raises the read enable
    a_r5_write_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_is_write) |=> !dram_rd_en);

endmodule

bind legacy_mem_decoder legacy_mem_decoder_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_is_write(acc_is_write),
    .acc_addr    (acc_addr),
    .dram_rd_en  (dram_rd_en),
    .dram_wr_en  (dram_wr_en),
    .fwd_to_bus  (fwd_to_bus)
);

// File: tb/test_legacy_mem_decoder.sv
`timescale 1ns/1ps
module test_legacy_mem_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_addr = 8'h00;
    logic [7:0]  cfg_wr_data = 8'h00;
    logic        smm_active = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_is_write = 1'b0;
    logic [31:0] acc_addr = 32'h0;
    logic        dram_rd_en, dram_wr_en, fwd_to_bus;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] sh_attr [7];
    logic [7:0] sh_smram;

    always #4 clk = ~clk;

    legacy_mem_decoder i_legacy_mem_decoder (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .smm_active(smm_active),
        .acc_valid(acc_valid), .acc_is_write(acc_is_write), .acc_addr(acc_addr),
        .dram_rd_en(dram_rd_en), .dram_wr_en(dram_wr_en), .fwd_to_bus(fwd_to_bus)
    );

    // expected {rd, wr, fwd} from the requirements
    function automatic logic [2:0] model(input logic [31:0] a, input bit w);
        int code;
        int seg;
        if (a >= 32'h100000 || a < 32'hA0000) code = 3;
        else if (a < 32'hC0000) code = ((smm_active && sh_smram[3]) || sh_smram[6]) ? 3 : 0;
        else if (a >= 32'hF0000) code = int'(sh_attr[0][5:4]);
        else begin
            seg  = int'((a - 32'hC0000) / 32'h4000);
            code = int'((sh_attr[1 + seg/2] >> (4*(seg%2))) & 8'h3);
        end
        case (code)
            3:       return w ? 3'b010 : 3'b100;
            1:       return w ? 3'b000 : 3'b100;
            default: return 3'b001;
        endcase
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp,
                         input logic [31:0] a);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%b expected=%b", req, a, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] off, input logic [7:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = off; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (off >= 8'h59 && off <= 8'h5F) sh_attr[off - 8'h59] = data;
        else if (off == 8'h72) sh_smram = data;
    endtask

    task automatic access(input string req, input logic [31:0] a, input bit w);
        logic [2:0] exp;
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_is_write = w;
        exp = model(a, w);
        @(negedge clk);
        acc_valid = 1'b0;
        check(req, {dram_rd_en, dram_wr_en, fwd_to_bus}, exp, a);
    endtask

    task automatic sweep(input string req);
        for (int s = 0; s < 12; s++) begin
            access(req, 32'hC0000 + s*32'h4000, 1'b0);
            access(req, 32'hC0000 + s*32'h4000 + 32'h3FFF, 1'b1);
        end
        access(req, 32'hF0000, 1'b0);
        access(req, 32'hFFFFF, 1'b1);
        access(req, 32'hA0000, 1'b0);
        access(req, 32'hBFFFF, 1'b1);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 7; i++) sh_attr[i] = 8'h00;
        sh_smram = 8'h02;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", {dram_rd_en, dram_wr_en, fwd_to_bus}, 3'b000, 32'h0);
        rst_n = 1'b1;
        smm_active = 1'b0;
        sweep("R1");
        smm_active = 1'b1;
        access("R1", 32'hA8000, 1'b0);
        access("R1", 32'hB0000, 1'b1);
        smm_active = 1'b0;
    endtask

    task automatic t_ignored();
        cfg_write(8'h58, 8'hFF);
        cfg_write(8'h60, 8'hFF);
        cfg_write(8'h71, 8'hFF);
        cfg_write(8'h73, 8'hFF);
        sweep("R9");
    endtask

    task automatic t_high();
        cfg_write(8'h59, 8'hCF); // bits[5:4]=00 despite other bits
        access("R2", 32'hF8000, 1'b0);
        cfg_write(8'h59, 8'h30); // RW
        access("R2", 32'hF0000, 1'b0);
        access("R4", 32'hFFFFF, 1'b1);
        cfg_write(8'h59, 8'h10); // RO
        access("R5", 32'hF1234, 1'b0);
        access("R5", 32'hF1234, 1'b1);
        cfg_write(8'h59, 8'h20); // bus
        access("R6", 32'hFC000, 1'b1);
    endtask

    task automatic t_segments();
        cfg_write(8'h5A, 8'hCD);
        cfg_write(8'h5B, 8'h3E);
        cfg_write(8'h5C, 8'h73);
        cfg_write(8'h5D, 8'h19);
        cfg_write(8'h5E, 8'h20);
        cfg_write(8'h5F, 8'hF7);
        sweep("R3");
        cfg_write(8'h5A, 8'h13);
        access("R4", 32'hC0000, 1'b1);
        access("R5", 32'hC4000, 1'b1);
        access("R5", 32'hC4000, 1'b0);
        cfg_write(8'h5A, 8'h20);
        access("R6", 32'hC0100, 1'b0);
        access("R6", 32'hC7FFF, 1'b1);
    endtask

    task automatic t_video();
        cfg_write(8'h72, 8'h08);
        smm_active = 1'b0;
        access("R7", 32'hA0000, 1'b0);
        smm_active = 1'b1;
        access("R7", 32'hA0000, 1'b0);
        access("R7", 32'hBFFFF, 1'b1);
        smm_active = 1'b0;
        cfg_write(8'h72, 8'h40);
        access("R7", 32'hB8000, 1'b1);
        cfg_write(8'h72, 8'h00);
        smm_active = 1'b1;
        access("R7", 32'hB8000, 1'b0);
        smm_active = 1'b0;
    endtask

    task automatic t_outside();
        access("R8", 32'h0000_0000, 1'b0);
        access("R8", 32'h0009_FFFF, 1'b1);
        access("R8", 32'h0010_0000, 1'b0);
        access("R8", 32'h000F_0000 | 32'h0100_0000, 1'b1);
        access("R8", 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_timing();
        // R10: config write visible to access on the next edge, idle gives no output
        cfg_write(8'h59, 8'h30);
        access("R10", 32'hF0000, 1'b0);
        @(negedge clk);
        check("R10", {dram_rd_en, dram_wr_en, fwd_to_bus}, 3'b000, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_ignored();
        t_high();
        t_segments();
        t_video();
        t_outside();
        t_timing();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule